// File: doc/BRIEF.md
# Dual-Channel Interval Timer

This block holds two independent 16-bit down-counting interval timers, named channel 0 and channel 2. Software programs them over a byte-wide write bus. A port selector routes each write to the control-word register or to one of the two channel data registers. A channel counts one step on every cycle in which the fixed-rate `tick_en` strobe is high, and it fires once every N ticks, where N is its programmed count. At each expiry it reloads that count and keeps running until software stops it.

A control word picks a channel and an operating-mode code. It accepts only the "low byte, then high byte" access form. A valid control word stores the mode and halts the channel, which then waits for a new count. The count is loaded with two data writes. One byte-order tracker is shared by both data ports, so writes to the two ports that interleave combine their bytes into a single count. Each channel drives a one-cycle `expire` pulse that can serve as an interrupt request. It also sets an expiry flag in its status byte. The status byte of channel 2 can be read on `rd_data`, and reading it clears the flag. Malformed control words are rejected, and `cmd_err` pulses.

Control path states: the byte tracker has two states. `SEQ_LO` waits for a low byte, and a data write moves it to `SEQ_HI`. In `SEQ_HI`, a data write loads the addressed channel and returns the tracker to `SEQ_LO`. Each channel has two states. `CH_IDLE` moves to `CH_RUN` when a count is loaded. `CH_RUN` moves back to `CH_IDLE` on a valid control word for that channel. A new load while in `CH_RUN` restarts the interval.

Top module: `pit_pair`

## Requirements
- R1: After reset, `expire` is 0, `cmd_err` is 0, `rd_data` is 0x00, both channels are idle and the byte tracker waits for a low byte.
- R2: `wr_sel` encodes the write target: 0 is the control word, 1 is the channel 0 data port, 2 is the channel 2 data port, and 3 is ignored. A write with `wr_sel`=3 does not advance the byte tracker and does not change the status byte.
- R3: In a control word, bits 7:6 select the channel (0 for channel 0, 2 for channel 2), bits 5:4 must be 11, and bits 3:1 are the mode code. A valid word stores the mode, halts that channel so it gives no further expiries until a new count is loaded, and leaves `cmd_err` low.
- R4: A control word with bits 7:6 equal to 1 or 3, or with bits 5:4 other than 11, raises `cmd_err` for exactly the one cycle after the write and changes no mode and no channel state.
- R5: The first data write stores the low byte and the next data write supplies the high byte. The 16-bit count is loaded into the channel addressed by the second write and that channel starts. The tracker is shared, so a low byte written to one port and a high byte written to the other load the second port's channel with both bytes.
- R6: After a count N is loaded at clock edge E, while `tick_en` is held high, the channel's `expire` bit is high for one cycle after each edge E+N, E+2N, E+3N and so on. `expire[0]` belongs to channel 0 and `expire[1]` to channel 2.
- R7: A loaded count of 0 gives an interval of 65536 ticks.
- R8: Channel 2's status byte on `rd_data` is {2'b00, expiry flag, 1'b0, mode[2:0], 1'b0}. Each expiry sets the flag (bit 5, 0x20). A cycle with `rd_en` high clears it at the next edge unless an expiry happens at that same edge.
- R9: Clock edges with `tick_en` low do not advance a running channel. The next expiry moves later by exactly the number of such edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Fixed-rate count strobe, one tick per high cycle |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 channel 0 data, 2 channel 2 data, 3 none |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Status read strobe for channel 2; clears the expiry flag |
| rd_data | output | 8 | Channel 2 status byte |
| expire | output | 2 | One-cycle expiry pulses: bit 0 for channel 0, bit 1 for channel 2 |
| cmd_err | output | 1 | One-cycle pulse after a rejected control word |

## Verification
The assertions check these rules on every cycle:
- An expiry pulse needs a tick on the edge that produced it.
- A running counter never holds zero.
- The flag is set whenever a pulse appears.
- A read clears the flag unless an expiry happens on the same edge.
- A valid control word leaves the channel idle and silent.
- An error pulse only follows a control-port write.
- A load always returns the tracker to the low-byte state.

Only the bench scenarios can show the exact expiry cycles for a given count, including the 65536-tick case for count 0. They also show the delay added by edges without a tick, the mixing of bytes across the two data ports, and that a rejected or ignored write leaves the visible status unchanged.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        PORT_CTRL  = 2'd0,
        PORT_DATA0 = 2'd1,
        PORT_DATA2 = 2'd2,
        PORT_NONE  = 2'd3
    } port_e;

    typedef enum logic {
        SEQ_LO = 1'b0,
        SEQ_HI = 1'b1
    } seq_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_e;

    localparam logic [1:0] ACCESS_LOHI = 2'b11;

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MODE_W = 3,
    parameter int NCH    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [NCH-1:0]        mode_we,
    output logic [MODE_W-1:0]     mode_val,
    output logic [NCH-1:0]        load,
    output logic [2*DATA_W-1:0]   load_val,
    output logic                  cmd_err
);

    seq_e              seq_q, seq_nx;
    logic [DATA_W-1:0] lo_q;
    logic              err_q;
    logic              ctrl_wr, data_wr, bad_word, data_idx;
    logic [1:0]        ch_field, acc_field;

    assign ch_field  = wr_data[DATA_W-1 -: 2];
    assign acc_field = wr_data[DATA_W-3 -: 2];
    assign mode_val  = wr_data[MODE_W:1];
    assign ctrl_wr   = wr_en && (wr_sel == PORT_CTRL);
    assign data_wr   = wr_en && ((wr_sel == PORT_DATA0) || (wr_sel == PORT_DATA2));
    assign data_idx  = (wr_sel == PORT_DATA2);
    assign bad_word  = ctrl_wr && ((acc_field != ACCESS_LOHI) ||
                                   (ch_field == 2'd1) || (ch_field == 2'd3));
    assign load_val  = {wr_data, lo_q};
    assign cmd_err   = err_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_LO;
        else        seq_q <= seq_nx;
    end

    // Next state and load strobes
    always_comb begin
        seq_nx = seq_q;
        load   = '0;
        unique case (seq_q)
            SEQ_LO: if (data_wr) seq_nx = SEQ_HI;
            SEQ_HI: if (data_wr) begin
                seq_nx         = SEQ_LO;
                load[data_idx] = 1'b1;
            end
        endcase
    end

    always_comb begin
        mode_we    = '0;
        mode_we[0] = ctrl_wr && !bad_word && (ch_field == 2'd0);
        mode_we[1] = ctrl_wr && !bad_word && (ch_field == 2'd2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= bad_word;
            if (data_wr && seq_q == SEQ_LO) lo_q <= wr_data;
        end
    end

    a_r4_err_after_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(wr_en && wr_sel == PORT_CTRL));
    a_r5_load_returns_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (|load) |=> (seq_q == SEQ_LO));
    a_r5_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load));
    a_r3_single_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_we));

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_val,
    input  logic              stat_clr,
    output logic              expire,
    output logic [7:0]        status
);

    localparam int EXT_W = CNT_W + 1;
    localparam logic [EXT_W-1:0] FULL_RANGE = EXT_W'(1) << CNT_W;
    localparam logic [EXT_W-1:0] ONE        = EXT_W'(1);

    ch_e               state_q, state_nx;
    logic [EXT_W-1:0]  cnt_q, reload_q, load_ext;
    logic [MODE_W-1:0] mode_q;
    logic              flag_q, expire_q, fire;

    assign load_ext = (load_val == '0) ? FULL_RANGE : {1'b0, load_val};
    assign fire     = (state_q == CH_RUN) && tick_en && (cnt_q == ONE) && !mode_we && !load;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CH_IDLE: if (load)    state_nx = CH_RUN;
            CH_RUN:  if (mode_we) state_nx = CH_IDLE;
                     else if (load) state_nx = CH_RUN;
        endcase
    end

    // Counter, flag and pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= ONE;
            reload_q <= ONE;
            mode_q   <= '0;
            flag_q   <= 1'b0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= fire;
            if (mode_we) mode_q <= mode_val;
            if (load) begin
                cnt_q    <= load_ext;
                reload_q <= load_ext;
            end else if (state_q == CH_RUN && tick_en) begin
                cnt_q <= (cnt_q == ONE) ? reload_q : cnt_q - ONE;
            end
            if (fire)          flag_q <= 1'b1;
            else if (stat_clr) flag_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        expire = expire_q;
        status = {2'b00, flag_q, 1'b0, mode_q, 1'b0};
    end

    a_r9_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> $past(tick_en));
    a_r6_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN) |-> (cnt_q != '0));
    a_r8_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> status[5]);
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !fire) |=> !status[5]);
    a_r3_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (state_q == CH_IDLE && !expire));

endmodule

// File: rtl/pit_pair.sv
module pit_pair
    import pit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic [1:0]        expire,
    output logic              cmd_err
);

    localparam int NCH   = 2;
    localparam int CNT_W = 2 * DATA_W;

    logic [NCH-1:0]    mode_we, load;
    logic [MODE_W-1:0] mode_val;
    logic [CNT_W-1:0]  load_val;
    logic [7:0]        stat0_unused;

    pit_ctrl_decode #(.DATA_W(DATA_W), .MODE_W(MODE_W), .NCH(NCH)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .mode_we  (mode_we),
        .mode_val (mode_val),
        .load     (load),
        .load_val (load_val),
        .cmd_err  (cmd_err)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        if (g == NCH - 1) begin : g_read
            pit_channel #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_ch (
                .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
                .load(load[g]), .load_val(load_val),
                .mode_we(mode_we[g]), .mode_val(mode_val),
                .stat_clr(rd_en), .expire(expire[g]), .status(rd_data)
            );
        end else begin : g_plain
            pit_channel #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_ch (
                .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
                .load(load[g]), .load_val(load_val),
                .mode_we(mode_we[g]), .mode_val(mode_val),
                .stat_clr(1'b0), .expire(expire[g]), .status(stat0_unused)
            );
        end
    end

endmodule

// File: tb/pit_pair_test.sv
module pit_pair_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] expire;
    logic       cmd_err;

    int unsigned cyc = 0;
    int checks = 0;
    int failures = 0;
    int unsigned exp_q [2][$];
    bit done = 1'b0;

    pit_pair uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .expire(expire), .cmd_err(cmd_err)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_to(input int unsigned c);
        while (cyc < c) @(negedge clk);
    endtask

    // Driver side: push the expected expiry cycles for a fresh load
    task automatic expect_pulses(input int ch, input int unsigned e, input int unsigned n, input int k);
        for (int i = 1; i <= k; i++) exp_q[ch].push_back(e + n * i);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Monitor: every pulse must match the queue head
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int ch = 0; ch < 2; ch++) begin
                if (expire[ch]) begin
                    if (exp_q[ch].size() == 0) begin
                        check("R6 unexpected pulse", int'(cyc), -1);
                    end else begin
                        check("R6 pulse cycle", int'(cyc), int'(exp_q[ch].pop_front()));
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        #1500000;
        if (!done) begin
            check("watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        int unsigned e, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 expire", int'(expire), 0);
        check("R1 cmd_err", int'(cmd_err), 0);
        check("R1 rd_data", int'(rd_data), 0);

        // R3 valid control word, channel 2, mode 3
        wr(2'd0, 8'hB6);
        check("R3 cmd_err low", int'(cmd_err), 0);
        check("R3 mode in status", int'(rd_data), 8'h06);

        // R4 rejected words
        wr(2'd0, 8'h90);
        check("R4 bad access err", int'(cmd_err), 1);
        check("R4 mode unchanged", int'(rd_data), 8'h06);
        wr(2'd0, 8'hC0);
        check("R4 readback err", int'(cmd_err), 1);
        wr(2'd0, 8'h70);
        check("R4 channel1 err", int'(cmd_err), 1);
        check("R4 mode unchanged", int'(rd_data), 8'h06);
        @(negedge clk);
        check("R4 one cycle", int'(cmd_err), 0);

        // R5/R2/R6 channel 2 count 5 with an ignored write between bytes
        wr(2'd2, 8'h05);
        wr(2'd3, 8'h55);
        check("R2 sel3 ignored", int'(rd_data), 8'h06);
        wr(2'd2, 8'h00);
        e = cyc;
        expect_pulses(1, e, 5, 3);
        wait_to(e + 16);
        check("R6 ch2 pulses seen", exp_q[1].size(), 0);
        check("R8 flag set", int'(rd_data), 8'h26);
        wr(2'd0, 8'hB6);
        rd_pulse();
        check("R8 read clears", int'(rd_data), 8'h06);
        repeat (10) @(negedge clk);
        check("R3 stopped", int'(expire), 0);

        // R6 channel 0 count 3
        wr(2'd0, 8'h36);
        wr(2'd1, 8'h03);
        wr(2'd1, 8'h00);
        e = cyc;
        expect_pulses(0, e, 3, 4);
        wait_to(e + 13);
        check("R6 ch0 pulses seen", exp_q[0].size(), 0);
        wr(2'd0, 8'h36);
        check("R8 ch0 not on status", int'(rd_data), 8'h06);
        repeat (6) @(negedge clk);

        // R5 interleaved bytes load channel 2 with 4
        wr(2'd1, 8'h04);
        wr(2'd2, 8'h00);
        e = cyc;
        expect_pulses(1, e, 4, 2);
        wait_to(e + 9);
        check("R5 mixed bytes", exp_q[1].size(), 0);
        wr(2'd0, 8'hB6);
        rd_pulse();
        repeat (6) @(negedge clk);

        // R9 tick gating on channel 0
        tick_en = 1'b0;
        wr(2'd1, 8'h04);
        wr(2'd1, 8'h00);
        repeat (10) @(negedge clk);
        check("R9 frozen", int'(expire), 0);
        c = cyc;
        tick_en = 1'b1;
        exp_q[0].push_back(c + 4);
        wait_to(c + 5);
        check("R9 delayed pulse", exp_q[0].size(), 0);
        wr(2'd0, 8'h36);
        repeat (6) @(negedge clk);

        // R7 count 0 on channel 2
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h00);
        e = cyc;
        exp_q[1].push_back(e + 65536);
        wait_to(e + 65535);
        check("R7 no early pulse", exp_q[1].size(), 1);
        wait_to(e + 65537);
        check("R7 full range", exp_q[1].size(), 0);
        check("R8 flag after wrap", int'(rd_data), 8'h26);
        wr(2'd0, 8'hB6);
        repeat (4) @(negedge clk);

        finish_run();
    end

endmodule